// File: doc/BRIEF.md
# Raster-synchronised video command processor

This block is a small sequencer that a display controller restarts on every frame. It reads 32-bit command words one at a time through a read port into video memory. An arbiter may hold that port back for any number of cycles. The block turns the commands into writes to six video control registers and into bursts of palette writes. It can hold itself until the beam reaches a given raster row, and it can call and return from subroutines through a small internal stack.

A frame-start pulse restarts the program at a fixed start address and empties the call stack. Programs usually put a jump at that address to reach their real code. A wait for row 32767 ends the frame's program, and the block then stays idle until the next frame-start. While the block waits on a row, the wait command is kept in the block's one-word instruction register, so the memory port is left free for other clients.

Top module: `raster_cmd_seq`

## Requirements
- R1: After reset, and until the first frame_start pulse, mem_req, reg_we, pal_we and stack_err are all low.
- R2: A frame_start pulse restarts execution at START_ADDR (word 0 by default) and empties the call stack. Every frame therefore runs the same program the same way.
- R3: The command code is bits [31:28]: 1 jump, 2 call, 3 wait, 4 register write, 5 palette burst. Code 0 and codes 6 to 15 do nothing, and execution moves on to the next word.
- R4: A register write takes its index from bits [26:24] and its 24-bit value from bits [23:0]. Indices 0 to 5 give a one-cycle reg_we pulse carrying that index and value. Indices 6 and 7 give no pulse.
- R5: A palette burst takes its first index from bits [7:0] and a count of bits [15:8] plus one. That many following words are written to consecutive palette indices, which wrap modulo 256. Execution then resumes after the last data word.
- R6: A wait takes its row from bits [15:0] and holds until raster_row is at least that row. During the wait no memory request is made. The word after the wait is always fetched and executed.
- R7: A wait for row 32767 halts the program. No memory request is made until the next frame_start.
- R8: A jump goes to the word address in bits [23:0]. A jump to address 0 is a return instead: it pops the stack and continues at the popped address.
- R9: A call pushes the address of the word that follows it and jumps to bits [23:0]. STACK_DEPTH (8) nested calls work without error.
- R10: A call with the stack full still jumps, but it pushes nothing. A return with the stack empty continues at the next word. Either case sets stack_err, which stays set until reset.
- R11: mem_addr holds steady while a request waits for mem_rvalid. A word is used only in the cycle where mem_rvalid is high. Register and palette writes are the same whatever the stall pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that restarts the program |
| raster_row | input | ROW_W | Current raster row |
| mem_req | output | 1 | Read request, held until mem_rvalid |
| mem_addr | output | AW | Word address of the request |
| mem_rvalid | input | 1 | Read data is valid for the pending request |
| mem_rdata | input | 32 | Read data |
| reg_we | output | 1 | Video register write strobe |
| reg_idx | output | 3 | Register index (0 to 5) |
| reg_val | output | 24 | Register value |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 8 | Palette entry index |
| pal_color | output | 32 | Palette colour word |
| stack_err | output | 1 | Sticky call-stack overflow/underflow flag |

## Verification
The same program is run under three memory stall patterns: no stall, a fixed stall of two cycles, and a stall that varies from beat to beat. Identical logs across these patterns show that a stalled response never shifts or duplicates a register or palette value. Comparing the total number of memory reads against the program's exact word count shows whether a wait re-reads memory or whether the word after a wait is lost. Two stack programs nest calls exactly to the stack depth and one level beyond it. They separate correct push/pop ordering from the overflow and underflow rules.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'h0,
    OP_JMP    = 4'h1,
    OP_JSR    = 4'h2,
    OP_WAIT   = 4'h3,
    OP_SETREG = 4'h4,
    OP_SETPAL = 4'h5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_WAIT, ST_PAL, ST_HALT
  } st_e;

  localparam int          WORD_W    = 32;
  localparam int          VREG_W    = 24;
  localparam int          VIDX_W    = 3;
  localparam int          PIDX_W    = 8;
  localparam int          NUM_VREGS = 6;
  localparam logic [15:0] HALT_ROW  = 16'h7FFF;

  function automatic logic [3:0] cmd_of(input logic [WORD_W-1:0] w);
    return w[31:28];
  endfunction

  function automatic logic [23:0] target_of(input logic [WORD_W-1:0] w);
    return w[23:0];
  endfunction

  function automatic logic [15:0] row_of(input logic [WORD_W-1:0] w);
    return w[15:0];
  endfunction

  function automatic logic [VIDX_W-1:0] ridx_of(input logic [WORD_W-1:0] w);
    return w[26:24];
  endfunction

  function automatic logic [VREG_W-1:0] rval_of(input logic [WORD_W-1:0] w);
    return w[23:0];
  endfunction

  function automatic logic [PIDX_W-1:0] pfirst_of(input logic [WORD_W-1:0] w);
    return w[7:0];
  endfunction

  // Number of data words in a palette burst: field value plus one (1..256).
  function automatic logic [8:0] pcount_of(input logic [WORD_W-1:0] w);
    return {1'b0, w[15:8]} + 9'd1;
  endfunction

endpackage

// File: rtl/rcs_fetch.sv
module rcs_fetch #(
  parameter int AW = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      want,
  input  logic [AW-1:0]             want_addr,
  input  logic                      load_word,
  output logic                      mem_req,
  output logic [AW-1:0]             mem_addr,
  input  logic                      mem_rvalid,
  input  logic [rcs_pkg::WORD_W-1:0] mem_rdata,
  output logic                      beat,
  output logic [rcs_pkg::WORD_W-1:0] word
);

  // One request at a time; address comes straight from the program counter,
  // which only moves on a beat, so it stays put across arbiter stalls.
  assign mem_req  = want;
  assign mem_addr = want_addr;
  assign beat     = want & mem_rvalid;

  // Instruction register doubles as the one-word cache used during waits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                word <= '0;
    else if (beat && load_word) word <= mem_rdata;
  end

endmodule

// File: rtl/rcs_callstack.sv
module rcs_callstack #(
  parameter int DEPTH = 8,
  parameter int AW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr,
  output logic          empty,
  output logic          push_err,
  output logic          pop_err
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] slot [DEPTH];
  logic          full;
  logic          do_push;
  logic          do_pop;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign do_push  = push && !full && !clear;
  assign do_pop   = pop && !empty && !clear;
  assign push_err = push && full && !clear;
  assign pop_err  = pop && empty && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (do_push) cnt <= cnt + 1'b1;
    else if (do_pop)  cnt <= cnt - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot[i] <= '0;
      else if (do_push && cnt == CW'(i))   slot[i] <= push_addr;
    end
  end

  always_comb begin
    top_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CW'(i + 1)) top_addr = slot[i];
    end
  end

endmodule

// File: rtl/raster_cmd_seq.sv
module raster_cmd_seq #(
  parameter int          AW          = 24,
  parameter int          ROW_W       = 16,
  parameter int          STACK_DEPTH = 8,
  parameter logic [23:0] START_ADDR  = 24'd0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_start,
  input  logic [ROW_W-1:0]            raster_row,
  output logic                        mem_req,
  output logic [AW-1:0]               mem_addr,
  input  logic                        mem_rvalid,
  input  logic [rcs_pkg::WORD_W-1:0]  mem_rdata,
  output logic                        reg_we,
  output logic [rcs_pkg::VIDX_W-1:0]  reg_idx,
  output logic [rcs_pkg::VREG_W-1:0]  reg_val,
  output logic                        pal_we,
  output logic [rcs_pkg::PIDX_W-1:0]  pal_idx,
  output logic [rcs_pkg::WORD_W-1:0]  pal_color,
  output logic                        stack_err
);
  import rcs_pkg::*;

  st_e               state;
  logic [AW-1:0]     pc;
  logic [PIDX_W-1:0] pidx;
  logic [8:0]        pcnt;

  logic              beat;
  logic [WORD_W-1:0] ir;
  op_e               op;
  logic [AW-1:0]     tgt;
  logic [ROW_W-1:0]  wait_row;
  logic              exec_now;
  logic              is_ret;

  // Named internal events, used by the bound checker.
  logic              in_wait;
  logic              halted;
  logic              stk_push;
  logic              stk_pop;
  logic              push_err;
  logic              pop_err;
  logic              stk_empty;
  logic [AW-1:0]     stk_top;

  assign op       = op_e'(cmd_of(ir));
  assign tgt      = AW'(target_of(ir));
  assign wait_row = ROW_W'(row_of(ir));
  assign exec_now = (state == ST_EXEC) && !frame_start;
  assign is_ret   = (tgt == '0);
  assign stk_push = exec_now && (op == OP_JSR);
  assign stk_pop  = exec_now && (op == OP_JMP) && is_ret;
  assign in_wait  = (state == ST_WAIT);
  assign halted   = (state == ST_HALT);

  rcs_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .want       ((state == ST_FETCH) || (state == ST_PAL)),
    .want_addr  (pc),
    .load_word  (state == ST_FETCH),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .beat       (beat),
    .word       (ir)
  );

  rcs_callstack #(.DEPTH(STACK_DEPTH), .AW(AW)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (frame_start),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_addr (pc),
    .top_addr  (stk_top),
    .empty     (stk_empty),
    .push_err  (push_err),
    .pop_err   (pop_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pc        <= AW'(START_ADDR);
      pidx      <= '0;
      pcnt      <= '0;
      reg_we    <= 1'b0;
      reg_idx   <= '0;
      reg_val   <= '0;
      pal_we    <= 1'b0;
      pal_idx   <= '0;
      pal_color <= '0;
      stack_err <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      pal_we <= 1'b0;
      if (push_err || pop_err) stack_err <= 1'b1;
      if (frame_start) begin
        state <= ST_FETCH;
        pc    <= AW'(START_ADDR);
      end else begin
        unique case (state)
          ST_FETCH: begin
            if (beat) begin
              pc    <= pc + 1'b1;
              state <= ST_EXEC;
            end
          end
          ST_EXEC: begin
            state <= ST_FETCH;
            case (op)
              OP_SETREG: begin
                if (ridx_of(ir) < VIDX_W'(NUM_VREGS)) begin
                  reg_we  <= 1'b1;
                  reg_idx <= ridx_of(ir);
                  reg_val <= rval_of(ir);
                end
              end
              OP_SETPAL: begin
                pidx  <= pfirst_of(ir);
                pcnt  <= pcount_of(ir);
                state <= ST_PAL;
              end
              OP_WAIT: begin
                state <= (row_of(ir) == HALT_ROW) ? ST_HALT : ST_WAIT;
              end
              OP_JMP: begin
                if (!is_ret)         pc <= tgt;
                else if (!stk_empty) pc <= stk_top;
              end
              OP_JSR: pc <= tgt;
              default: ;
            endcase
          end
          ST_WAIT: begin
            if (raster_row >= wait_row) state <= ST_FETCH;
          end
          ST_PAL: begin
            if (beat) begin
              pal_we    <= 1'b1;
              pal_idx   <= pidx;
              pal_color <= mem_rdata;
              pidx      <= pidx + 1'b1;
              pc        <= pc + 1'b1;
              pcnt      <= pcnt - 1'b1;
              if (pcnt == 9'd1) state <= ST_FETCH;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          reg_we,
  input logic [2:0]    reg_idx,
  input logic          pal_we,
  input logic          stack_err,
  input logic          in_wait,
  input logic          halted,
  input logic          push_err,
  input logic          pop_err
);

  assert_req_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> mem_req);

  assert_vreg_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_idx <= 3'd5));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && pal_we));

  assert_wait_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !mem_req);

  assert_halt_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_err || pop_err) |=> stack_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid && !frame_start) |=> (mem_req && $stable(mem_addr)));

endmodule

bind raster_cmd_seq rcs_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_rvalid  (mem_rvalid),
  .reg_we      (reg_we),
  .reg_idx     (reg_idx),
  .pal_we      (pal_we),
  .stack_err   (stack_err),
  .in_wait     (in_wait),
  .halted      (halted),
  .push_err    (push_err),
  .pop_err     (pop_err)
);

// File: tb/sim_raster_cmd_seq.sv
`timescale 1ns/1ps
module sim_raster_cmd_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [15:0] raster_row;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        reg_we;
  logic [2:0]  reg_idx;
  logic [23:0] reg_val;
  logic        pal_we;
  logic [7:0]  pal_idx;
  logic [31:0] pal_color;
  logic        stack_err;

  always #2 clk = ~clk;

  raster_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .raster_row(raster_row),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_color(pal_color), .stack_err(stack_err)
  );

  int checks = 0;
  int errors = 0;
  int gcyc   = 0;
  int smode  = 0;
  int reads  = 0;
  int reqcyc = 0;
  int wcnt   = 0;
  int tk     = 0;
  logic [31:0] mem [128];

  int          nreg = 0;
  int          npal = 0;
  logic [2:0]  lr_idx [64];
  logic [23:0] lr_val [64];
  logic [15:0] lr_row [64];
  logic [7:0]  lp_idx [64];
  logic [31:0] lp_col [64];
  logic [15:0] lp_row [64];

  // Command encoders written from the requirement field positions.
  function automatic logic [31:0] w_jmp(input logic [23:0] t);
    return {4'h1, 4'h0, t};
  endfunction
  function automatic logic [31:0] w_jsr(input logic [23:0] t);
    return {4'h2, 4'h0, t};
  endfunction
  function automatic logic [31:0] w_wait(input logic [15:0] r);
    return {4'h3, 12'h0, r};
  endfunction
  function automatic logic [31:0] w_setreg(input logic [2:0] i, input logic [23:0] v);
    return {4'h4, 1'b0, i, v};
  endfunction
  function automatic logic [31:0] w_setpal(input logic [7:0] first, input logic [8:0] n);
    logic [8:0] m;
    m = n - 9'd1;
    return {4'h5, 12'h0, m[7:0], first};
  endfunction

  function automatic int stall_for(input int mode, input int cyc);
    if (mode == 0) return 0;
    if (mode == 1) return 2;
    return (cyc * 7 + 1) % 4;
  endfunction

  // Raster row: advances every 40 cycles, restarts on frame_start.
  always @(posedge clk) begin
    if (!rst_n || frame_start) begin
      raster_row <= 16'd0;
      tk <= 0;
    end else if (tk == 39) begin
      tk <= 0;
      raster_row <= raster_row + 16'd1;
    end else begin
      tk <= tk + 1;
    end
  end

  // Memory model with a stall pattern; responds to the current request only.
  always @(negedge clk) begin
    if (mem_req) reqcyc = reqcyc + 1;
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      wcnt       = 0;
    end else if (mem_req && wcnt == 0) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem[mem_addr[6:0]];
      reads      = reads + 1;
      wcnt       = stall_for(smode, gcyc);
    end else begin
      mem_rvalid = 1'b0;
      if (mem_req && wcnt > 0) wcnt = wcnt - 1;
    end
  end

  // Strobe logger.
  always @(negedge clk) begin
    if (reg_we && nreg < 64) begin
      lr_idx[nreg] = reg_idx; lr_val[nreg] = reg_val; lr_row[nreg] = raster_row;
      nreg = nreg + 1;
    end
    if (pal_we && npal < 64) begin
      lp_idx[npal] = pal_idx; lp_col[npal] = pal_color; lp_row[npal] = raster_row;
      npal = npal + 1;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    gcyc <= gcyc + 1;
    if (gcyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL R11 watchdog expired actual=%0d expected<150000", gcyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 128; i++) mem[i] = w_wait(16'h7FFF);
  endtask

  localparam logic [31:0] C0 = 32'h11223344, C1 = 32'h55667788, C2 = 32'h99AABBCC;
  localparam logic [31:0] D0 = 32'hDEADBEEF, D1 = 32'h0BADF00D;

  task automatic load_prog1();
    fill_mem();
    mem[0]  = w_jmp(24'd15);
    mem[15] = 32'hE000_0005;              // undefined code, no effect (R3)
    mem[16] = w_setreg(3'd5, 24'd2);
    mem[17] = w_jsr(24'd40);
    mem[18] = w_wait(16'd3);
    mem[19] = w_setreg(3'd0, 24'h001000);  // right after a wait (R6)
    mem[20] = w_setpal(8'd10, 9'd3);
    mem[21] = C0; mem[22] = C1; mem[23] = C2;
    mem[24] = w_setreg(3'd6, 24'h00ABCD);  // index 6: no strobe (R4)
    mem[25] = w_jmp(24'd0);                // return on empty stack (R10)
    mem[26] = w_wait(16'd5);
    mem[27] = w_setpal(8'd255, 9'd2);      // wraps to index 0 (R5)
    mem[28] = D0; mem[29] = D1;
    mem[30] = w_setreg(3'd4, 24'd1280);
    mem[31] = w_wait(16'h7FFF);
    mem[40] = w_setreg(3'd3, 24'd7);
    mem[41] = w_jmp(24'd0);
  endtask

  // Eight nested calls; deeper=1 adds a ninth call that overflows.
  task automatic load_prog2(input bit deeper);
    fill_mem();
    mem[0] = w_jmp(24'd50);
    for (int i = 0; i < 8; i++) begin
      mem[50 + 2*i] = w_jsr(24'(52 + 2*i));
      mem[51 + 2*i] = w_jmp(24'd0);
    end
    mem[51] = w_jmp(24'd80);
    if (deeper) begin
      mem[66] = w_jsr(24'd68);
      mem[68] = w_setreg(3'd2, 24'h000111);
      mem[69] = w_jmp(24'd0);
    end else begin
      mem[66] = w_setreg(3'd2, 24'h000111);
      mem[67] = w_jmp(24'd0);
    end
    mem[80] = w_setreg(3'd2, 24'h000222);
    mem[81] = w_wait(16'h7FFF);
  endtask

  task automatic run_prog1(input int mode);
    int rb, rq, nb, pb;
    smode = mode;
    load_prog1();
    do_reset();
    rb = reads; nb = nreg; pb = npal;
    pulse_frame();
    cycles(300);
    rq = reqcyc;
    cycles(100);
    chk(reqcyc == rq, "R7 requests after halt", reqcyc - rq, 0);
    chk(reads - rb == 20, "R6 memory reads per frame", reads - rb, 20);
    chk(nreg - nb == 4, "R4 register write count", nreg - nb, 4);
    chk(lr_idx[nb] == 5 && lr_val[nb] == 24'd2, "R3 first write after undefined code", lr_val[nb], 2);
    chk(lr_idx[nb+1] == 3 && lr_val[nb+1] == 24'd7, "R9 write in subroutine", lr_val[nb+1], 7);
    chk(lr_idx[nb+2] == 0 && lr_val[nb+2] == 24'h1000, "R6 word after wait kept", lr_val[nb+2], 24'h1000);
    chk(lr_row[nb+2] == 16'd3, "R6 release row", lr_row[nb+2], 3);
    chk(lr_idx[nb+3] == 4 && lr_val[nb+3] == 24'd1280 && lr_row[nb+3] == 16'd5,
        "R8 fall-through after failed return", lr_val[nb+3], 1280);
    chk(npal - pb == 5, "R5 palette write count", npal - pb, 5);
    chk(lp_idx[pb] == 10 && lp_col[pb] == C0, "R11 palette first entry", lp_col[pb], C0);
    chk(lp_idx[pb+1] == 11 && lp_col[pb+1] == C1, "R5 palette second entry", lp_col[pb+1], C1);
    chk(lp_idx[pb+2] == 12 && lp_col[pb+2] == C2, "R5 palette third entry", lp_col[pb+2], C2);
    chk(lp_idx[pb+3] == 255 && lp_col[pb+3] == D0 && lp_row[pb+3] == 16'd5,
        "R5 palette at 255", lp_col[pb+3], D0);
    chk(lp_idx[pb+4] == 0 && lp_col[pb+4] == D1, "R5 palette index wrap", lp_idx[pb+4], 0);
    chk(stack_err == 1'b1, "R10 underflow flag", stack_err, 1);
    // Second frame of the same program.
    rb = reads; nb = nreg;
    pulse_frame();
    cycles(400);
    chk(reads - rb == 20, "R2 reads on restarted frame", reads - rb, 20);
    chk(nreg - nb == 4 && lr_val[nb] == 24'd2, "R2 restarted frame first write", lr_val[nb], 2);
    chk(stack_err == 1'b1, "R10 flag stays set", stack_err, 1);
  endtask

  task automatic run_prog2(input bit deeper, input int mode);
    int rb, nb;
    smode = mode;
    load_prog2(deeper);
    do_reset();
    rb = reads; nb = nreg;
    pulse_frame();
    cycles(300);
    chk(reads - rb == (deeper ? 22 : 21), "R9 reads through nested calls", reads - rb, deeper ? 22 : 21);
    chk(nreg - nb == 2, "R8 writes through returns", nreg - nb, 2);
    chk(lr_val[nb] == 24'h111 && lr_val[nb+1] == 24'h222, "R8 return order",
        lr_val[nb+1], 24'h222);
    chk(stack_err == deeper, deeper ? "R10 overflow flag" : "R9 no error at full depth",
        stack_err, deeper);
  endtask

  initial begin
    int rq, bad;
    fill_mem();
    do_reset();
    rq = reqcyc; bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (reg_we || pal_we || stack_err) bad = bad + 1;
    end
    chk(reqcyc == rq, "R1 no request before frame start", reqcyc - rq, 0);
    chk(bad == 0, "R1 strobes and flag low after reset", bad, 0);
    for (int m = 0; m < 3; m++) run_prog1(m);
    for (int m = 0; m < 3; m++) begin
      run_prog2(1'b0, m);
      run_prog2(1'b1, m);
    end
    summary();
    $finish;
  end

endmodule